// File: doc/BRIEF.md
# Serial Gain Control Port

This block is the control side of one channel of a programmable gain amplifier. A host talks to it over four wires: a serial clock, an active-low frame select, a serial data input and a serial data output. Each frame is eight bits long. The first bit picks the direction (1 writes, 0 reads), the second bit carries no meaning, and the last six bits are the gain word, least significant bit first. A write frame stores the word in a six-bit gain register. A read frame shifts the stored word back out on the data output, one bit on each falling serial clock edge.

The stored code drives a decoder. Codes 1 to 42 give a signed gain in dB equal to the code minus ten, which covers -9 dB to +32 dB in 1 dB steps. Every other code means mute. A channel enable input forces mute while it is low and leaves the stored code untouched. The serial inputs are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and its edges are detected in the system clock domain. A dual-channel part is built from two independent instances.

Top module: `gain_ctrl_port`

## Requirements
- R1: After reset the stored code is 0, `mute_o` is 1, `gain_db_o` is 0 and `sdata_o` is 0.
- R2: The stored code is replaced only by a frame with exactly eight rising serial clock edges while `frame_ni` is low and a first bit of 1. The new code appears on `gain_code_o` after `frame_ni` returns high. The second bit may take either value. Bits three to eight form the code, with bit three as code bit 0 and bit eight as code bit 5.
- R3: A write frame with fewer or more than eight rising edges, and any frame whose first bit is 0, leaves `gain_code_o` unchanged.
- R4: Serial clock and data activity while `frame_ni` is high leaves `gain_code_o` unchanged.
- R5: In a read frame (first bit 0), the falling edge after rising edge k, for k from 2 to 7, drives code bit k-2 onto `sdata_o`. The host therefore samples code bit 0 before rising edge 3 and code bit 5 before rising edge 8.
- R6: `sdata_o` is 0 whenever `frame_ni` is high and in every bit slot of a write frame.
- R7: With the channel enabled, a code c from 1 to 42 gives `mute_o` = 0 and `gain_db_o` = c - 10, as 7-bit two's complement.
- R8: Codes 0 and 43 to 63 give `mute_o` = 1 and `gain_db_o` = 0.
- R9: While `chan_en_i` is 0, `mute_o` is 1 and `gain_db_o` is 0. The stored code stays as it is, can still be written and read over the serial port, and decodes again once `chan_en_i` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous, idles low |
| frame_ni | input | 1 | Frame select, active low, asynchronous |
| sdata_i | input | 1 | Serial data from the host |
| chan_en_i | input | 1 | Channel enable; low forces mute |
| sdata_o | output | 1 | Serial read-back data |
| gain_code_o | output | 6 | Stored gain code |
| gain_db_o | output | 7 | Signed gain in dB, 0 when muted |
| mute_o | output | 1 | Mute flag |

## Verification
The assertions assume that the serial clock, frame select and data each hold steady for at least three system clock cycles between changes, so that every synchronized edge is seen once. They also assume that the frame select never changes in the same synchronized cycle as a serial clock edge. The bench drives every serial signal at a falling system clock edge and holds each serial half period for six system cycles. It moves the frame select only while the serial clock is low and has been steady for a full half period, so the stimulus stays inside these assumptions.

// File: rtl/gcp_pkg.sv
package gcp_pkg;
  parameter int unsigned GAIN_W       = 6;
  parameter int unsigned SYNC_STAGES  = 2;
  parameter int unsigned CODE_MIN     = 1;
  parameter int unsigned CODE_MAX     = 42;
  parameter int unsigned ZERO_DB_CODE = 10;
endpackage

// File: rtl/gcp_sync.sv
module gcp_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gcp_frame.sv
module gcp_frame #(
  parameter int unsigned GW    = 6,
  parameter int unsigned CNT_W = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_rise_i,
  input  logic          sclk_fall_i,
  input  logic          frame_act_i,
  input  logic          frame_start_i,
  input  logic          frame_end_i,
  input  logic          sdata_i,
  output logic [GW-1:0] gain_o,
  output logic          sdata_o,
  output logic          commit_o
);
  localparam int unsigned FRAME_LEN = GW + 2;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_LEN  = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(2);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_LEN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             wr_mode_q;
  logic [GW-1:0]    shift_q;
  logic [GW-1:0]    gain_q;
  logic             sdo_q;

  logic             rise_act, fall_act, rd_slot;
  logic [CNT_W-1:0] rd_idx;
  logic [GW-1:0]    rd_shift;

  assign rise_act = sclk_rise_i & frame_act_i;
  assign fall_act = sclk_fall_i & frame_act_i;
  assign commit_o = frame_end_i & wr_mode_q & (cnt_q == CNT_LEN);
  // read slot k-2 follows rising edge k, k in 2..FRAME_LEN-1
  assign rd_slot  = !wr_mode_q && (cnt_q >= CNT_DATA) && (cnt_q <= CNT_LAST);
  assign rd_idx   = cnt_q - CNT_DATA;
  assign rd_shift = gain_q >> rd_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      wr_mode_q <= 1'b0;
      shift_q   <= '0;
    end else if (frame_start_i) begin
      cnt_q     <= '0;
      wr_mode_q <= 1'b0;
      shift_q   <= '0;
    end else if (rise_act) begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      if (cnt_q == '0) wr_mode_q <= sdata_i;
      if (cnt_q >= CNT_DATA) shift_q <= {sdata_i, shift_q[GW-1:1]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       gain_q <= '0;
    else if (commit_o) gain_q <= shift_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           sdo_q <= 1'b0;
    else if (!frame_act_i) sdo_q <= 1'b0;
    else if (fall_act)     sdo_q <= rd_slot & rd_shift[0];
  end

  assign gain_o  = gain_q;
  assign sdata_o = sdo_q;
endmodule

// File: rtl/gcp_decode.sv
module gcp_decode #(
  parameter int unsigned GW       = 6,
  parameter int unsigned DB_W     = 7,
  parameter int unsigned CODE_MIN = 1,
  parameter int unsigned CODE_MAX = 42,
  parameter int unsigned ZERO_DB  = 10
) (
  input  logic                   en_i,
  input  logic [GW-1:0]          code_i,
  output logic signed [DB_W-1:0] db_o,
  output logic                   mute_o
);
  localparam logic [GW-1:0] C_LO = GW'(CODE_MIN);
  localparam logic [GW-1:0] C_HI = GW'(CODE_MAX);
  localparam logic signed [DB_W-1:0] OFFS = DB_W'(ZERO_DB);

  logic                   in_rng;
  logic signed [DB_W-1:0] raw_db;

  assign in_rng = (code_i >= C_LO) && (code_i <= C_HI);
  assign raw_db = $signed({{(DB_W-GW){1'b0}}, code_i}) - OFFS;

  always_comb begin
    mute_o = !(en_i && in_rng);
    db_o   = mute_o ? '0 : raw_db;
  end
endmodule

// File: rtl/gain_ctrl_port.sv
module gain_ctrl_port #(
  parameter int unsigned GAIN_W       = gcp_pkg::GAIN_W,
  parameter int unsigned SYNC_STAGES  = gcp_pkg::SYNC_STAGES,
  parameter int unsigned CODE_MIN     = gcp_pkg::CODE_MIN,
  parameter int unsigned CODE_MAX     = gcp_pkg::CODE_MAX,
  parameter int unsigned ZERO_DB_CODE = gcp_pkg::ZERO_DB_CODE,
  parameter int unsigned DB_W         = GAIN_W + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sclk_i,
  input  logic                   frame_ni,
  input  logic                   sdata_i,
  input  logic                   chan_en_i,
  output logic                   sdata_o,
  output logic [GAIN_W-1:0]      gain_code_o,
  output logic signed [DB_W-1:0] gain_db_o,
  output logic                   mute_o
);
  localparam int unsigned FRAME_LEN = GAIN_W + 2;
  localparam int unsigned CNT_W     = $clog2(FRAME_LEN + 2);

  // bit order: {sdata, frame_n, sclk}
  logic [2:0] pins_s;
  logic       sclk_q, frame_q;
  logic       sclk_rise, sclk_fall, frame_act, frame_start, frame_end, commit;

  gcp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sdata_i, frame_ni, sclk_i}),
    .q_o   (pins_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      frame_q <= 1'b1;
    end else begin
      sclk_q  <= pins_s[0];
      frame_q <= pins_s[1];
    end
  end

  assign sclk_rise   =  pins_s[0] & ~sclk_q;
  assign sclk_fall   = ~pins_s[0] &  sclk_q;
  assign frame_act   = ~pins_s[1];
  assign frame_start = ~pins_s[1] &  frame_q;
  assign frame_end   =  pins_s[1] & ~frame_q;

  gcp_frame #(.GW(GAIN_W), .CNT_W(CNT_W)) u_frame (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sclk_rise_i  (sclk_rise),
    .sclk_fall_i  (sclk_fall),
    .frame_act_i  (frame_act),
    .frame_start_i(frame_start),
    .frame_end_i  (frame_end),
    .sdata_i      (pins_s[2]),
    .gain_o       (gain_code_o),
    .sdata_o      (sdata_o),
    .commit_o     (commit)
  );

  gcp_decode #(
    .GW(GAIN_W), .DB_W(DB_W), .CODE_MIN(CODE_MIN),
    .CODE_MAX(CODE_MAX), .ZERO_DB(ZERO_DB_CODE)
  ) u_dec (
    .en_i  (chan_en_i),
    .code_i(gain_code_o),
    .db_o  (gain_db_o),
    .mute_o(mute_o)
  );
endmodule

// File: rtl/gcp_chk.sv
module gcp_chk #(
  parameter int unsigned GAIN_W = 6,
  parameter int unsigned DB_W   = 7
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   chan_en_i,
  input logic                   sdata_o,
  input logic [GAIN_W-1:0]      gain_code_o,
  input logic signed [DB_W-1:0] gain_db_o,
  input logic                   mute_o,
  input logic                   frame_act_i,
  input logic                   commit_i
);
  AST_RESET_CODE: assert property (@(posedge clk_i) !rst_ni |=> (gain_code_o == '0)); // R1
  AST_CODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(gain_code_o) |-> $past(commit_i)); // R3
  AST_SDO_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_act_i |=> !sdata_o); // R6
  AST_DB_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mute_o |-> (gain_db_o >= -7'sd9) && (gain_db_o <= 7'sd32)); // R7
  AST_MUTE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mute_o |-> (gain_db_o == '0)); // R8
  AST_OFF_MUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chan_en_i |-> mute_o); // R9
  AST_OFF_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chan_en_i && !commit_i) |=> $stable(gain_code_o)); // R9
endmodule

bind gain_ctrl_port gcp_chk #(.GAIN_W(GAIN_W), .DB_W(DB_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .chan_en_i  (chan_en_i),
  .sdata_o    (sdata_o),
  .gain_code_o(gain_code_o),
  .gain_db_o  (gain_db_o),
  .mute_o     (mute_o),
  .frame_act_i(frame_act),
  .commit_i   (commit)
);

// File: tb/sim_gain_ctrl_port.sv
module sim_gain_ctrl_port;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n, sclk, frame_n, sdata, en;
  logic sdo, mute;
  logic [5:0] code;
  logic signed [6:0] db;
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gain_ctrl_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .frame_ni(frame_n),
    .sdata_i(sdata), .chan_en_i(en), .sdata_o(sdo),
    .gain_code_o(code), .gain_db_o(db), .mute_o(mute)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_db(input int c, input bit on);
    return (on && c >= 1 && c <= 42) ? c - 10 : 0;
  endfunction

  function automatic int exp_mute(input int c, input bit on);
    return (on && c >= 1 && c <= 42) ? 0 : 1;
  endfunction

  task automatic send(input bit rw, input bit dc, input logic [5:0] w,
                      input int nbits, output logic [5:0] rd);
    rd = '0;
    frame_n = 1'b0;
    tick(H);
    for (int i = 0; i < nbits; i++) begin
      sclk  = 1'b0;
      sdata = (i == 0) ? rw : (i == 1) ? dc : (i < 8) ? w[i-2] : 1'b1;
      tick(H);
      if (i >= 2 && i <= 7) rd[i-2] = sdo;
      sclk = 1'b1;
      tick(H);
    end
    sclk = 1'b0;
    tick(H);
    frame_n = 1'b1;
    sdata = 1'b0;
    tick(H);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [5:0] rd;
    rst_n = 1'b0; sclk = 1'b0; frame_n = 1'b1; sdata = 1'b0; en = 1'b1;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    check("R1 code", int'(code), 0);
    check("R1 mute", int'(mute), 1);
    check("R1 db", int'(db), 0);
    check("R1 sdo", int'(sdo), 0);

    // exhaustive write/read sweep; dc bit toggled per code
    for (int c = 0; c < 64; c++) begin
      send(1'b1, ~c[0], 6'(c), 8, rd);
      check("R6 sdo during write", int'(rd), 0);
      check("R2 code", int'(code), c);
      check("R7/R8 db", int'(db), exp_db(c, 1'b1));
      check("R7/R8 mute", int'(mute), exp_mute(c, 1'b1));
      send(1'b0, 1'b1, 6'h3f, 8, rd);
      check("R5 readback", int'(rd), c);
      check("R3 read keeps code", int'(code), c);
      check("R6 sdo idle", int'(sdo), 0);
    end

    send(1'b1, 1'b0, 6'd20, 8, rd);
    check("R2 write 20", int'(code), 20);
    send(1'b1, 1'b0, 6'd5, 7, rd);
    check("R3 short frame", int'(code), 20);
    send(1'b1, 1'b1, 6'd33, 9, rd);
    check("R3 long frame", int'(code), 20);
    send(1'b0, 1'b0, 6'd50, 8, rd);
    check("R3 read frame no write", int'(code), 20);

    // toggling with frame high
    for (int i = 0; i < 10; i++) begin
      sclk = 1'b0; sdata = 1'b1; tick(H);
      sclk = 1'b1; tick(H);
    end
    sclk = 1'b0; sdata = 1'b0; tick(H);
    check("R4 idle activity", int'(code), 20);
    check("R6 sdo idle after toggles", int'(sdo), 0);
    send(1'b0, 1'b0, 6'd0, 8, rd);
    check("R4 readback after idle activity", int'(rd), 20);

    en = 1'b0;
    tick(2);
    check("R9 mute off", int'(mute), 1);
    check("R9 db off", int'(db), 0);
    check("R9 code kept", int'(code), 20);
    send(1'b1, 1'b0, 6'd41, 8, rd);
    check("R9 write while off", int'(code), 41);
    check("R9 still muted", int'(mute), 1);
    send(1'b0, 1'b0, 6'd0, 8, rd);
    check("R9 read while off", int'(rd), 41);
    en = 1'b1;
    tick(2);
    check("R9 db restored", int'(db), 31);
    check("R9 mute cleared", int'(mute), 0);

    done = 1;
    summary();
    $finish;
  end
endmodule